// File: doc/BRIEF.md
# Far-End Path Status Latch

This block is a sticky status register for remote path defects. A receive-side detector decodes the path status byte and drives two indications into the block. The first is a remote payload defect, raised for a payload mismatch or for lost cell delineation. The second is a remote server defect, raised for an alarm indication signal or for lost pointer; both of these arrive on the same line. Either input may be a single-cycle pulse or a level held for many cycles. Each indication latches into its own bit of a 16-bit status word, and the bit stays set until management clears it.

Management reads the word with a read strobe and clears it with a clear strobe. No address is involved in either access. The clear strobe carries a mask, and only the bits whose mask bit is 1 are cleared. A defect that arrives in the same cycle as a clear that targets its bit wins over that clear. A read that coincides with a clear returns the value before the clear. Together these rules let software read the word, then clear exactly the bits it saw, without losing a defect that arrived in between.

Top module: `fe_status_latch`

## Requirements
- R1: A status bit becomes 1 on the clock edge after its defect input is high for at least one cycle, pulse or level. It stays 1 until a clear selects it, whatever the input does after that.
- R2: The remote payload defect input (`far_payload_i`) latches into bit 10 of the status word.
- R3: The remote server defect input (`far_server_i`) latches into bit 8 of the status word. This input already combines alarm indication and lost pointer.
- R4: Every bit other than 8 and 10, bit 9 included, always reads 0. Defect inputs, clear masks and resets never make such a bit read 1.
- R5: When `clr_stb_i` is 1, each latched bit whose bit in `clr_mask_i` is 1 goes to 0 on that edge. Bits whose mask bit is 0 keep their value.
- R6: When a defect input is high in the same cycle as a clear that selects its bit, the bit is 1 after the edge.
- R7: On an edge where `rd_stb_i` is 1, `rd_data_o` takes the latched word as it was before that edge's set and clear updates. Between read strobes `rd_data_o` holds its value.
- R8: A synchronous active-high `rst` sets the latched word and `rd_data_o` to 0.
- R9: `clr_mask_i` has no effect while `clr_stb_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| far_payload_i | input | 1 | Remote payload defect indication (pulse or level) |
| far_server_i | input | 1 | Remote server defect indication (pulse or level) |
| rd_stb_i | input | 1 | Read strobe; captures the latched word |
| rd_data_o | output | 16 | Registered read data |
| clr_stb_i | input | 1 | Clear strobe |
| clr_mask_i | input | 16 | Per-bit clear selection, 1 clears |

## Verification
A flip-flop with a wrong value shows at `rd_data_o` on the edge of the next read strobe. The read samples the pre-update word, so a lost set or a spurious clear appears one edge after the read strobe. It does not appear earlier, because the output is registered and holds between reads. The scenarios therefore read after every stimulus of interest: after each set, after each masked clear, and around clears that collide with sets. A defect dropped by a colliding clear shows up as 0 in the read that follows, not as a late set.

// File: rtl/fe_status_pkg.sv
package fe_status_pkg;

  localparam int unsigned FE_WORD_W  = 16;
  localparam int unsigned FE_PAY_POS = 10;
  localparam int unsigned FE_SRV_POS = 8;

  // Mask of implemented bit positions for a given word width and layout.
  function automatic logic [63:0] fe_valid_mask(input int unsigned pay_pos,
                                                input int unsigned srv_pos);
    logic [63:0] m;
    m = '0;
    m[pay_pos] = 1'b1;
    m[srv_pos] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/fe_event_map.sv
module fe_event_map #(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned PAY_POS = 10,
  parameter int unsigned SRV_POS = 8
) (
  input  logic              far_payload_i,
  input  logic              far_server_i,
  output logic [WORD_W-1:0] set_vec_o
);
  // Place each defect indication at its fixed position in the word.
  always_comb begin
    set_vec_o          = '0;
    set_vec_o[PAY_POS] = far_payload_i;
    set_vec_o[SRV_POS] = far_server_i;
  end
endmodule

// File: rtl/fe_sticky_cell.sv
module fe_sticky_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // Set has priority over clear so a coincident event is never lost.
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/fe_read_reg.sv
module fe_read_reg #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_stb_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] rd_data_o
);
  always_ff @(posedge clk) begin
    if (rst)           rd_data_o <= '0;
    else if (rd_stb_i) rd_data_o <= word_i;
  end
endmodule

// File: rtl/fe_status_latch.sv
module fe_status_latch
  import fe_status_pkg::*;
#(
  parameter int unsigned WORD_W  = FE_WORD_W,
  parameter int unsigned PAY_POS = FE_PAY_POS,
  parameter int unsigned SRV_POS = FE_SRV_POS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              far_payload_i,
  input  logic              far_server_i,
  input  logic              rd_stb_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              clr_stb_i,
  input  logic [WORD_W-1:0] clr_mask_i
);
  localparam logic [63:0]       VALID_FULL = fe_valid_mask(PAY_POS, SRV_POS);
  localparam logic [WORD_W-1:0] VALID      = VALID_FULL[WORD_W-1:0];

  logic [WORD_W-1:0] set_vec;
  logic [WORD_W-1:0] clr_vec;
  logic [WORD_W-1:0] held_w;
  logic              unused_bits;

  fe_event_map #(.WORD_W(WORD_W), .PAY_POS(PAY_POS), .SRV_POS(SRV_POS)) u_map (
    .far_payload_i (far_payload_i),
    .far_server_i  (far_server_i),
    .set_vec_o     (set_vec)
  );

  assign clr_vec = clr_mask_i & {WORD_W{clr_stb_i}};

  // Reserved positions carry no storage; their inputs are folded away.
  assign unused_bits = ^((set_vec | clr_vec) & ~VALID);

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    if (VALID[i]) begin : g_cell
      fe_sticky_cell u_cell (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_vec[i]),
        .clr_i (clr_vec[i]),
        .q_o   (held_w[i])
      );
    end else begin : g_rsvd
      assign held_w[i] = 1'b0;
    end
  end

  fe_read_reg #(.WORD_W(WORD_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_stb_i  (rd_stb_i),
    .word_i    (held_w),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/fe_status_latch_chk.sv
module fe_status_latch_chk
  import fe_status_pkg::*;
#(
  parameter int unsigned WORD_W  = FE_WORD_W,
  parameter int unsigned PAY_POS = FE_PAY_POS,
  parameter int unsigned SRV_POS = FE_SRV_POS
) (
  input logic              clk,
  input logic              rst,
  input logic              far_payload_i,
  input logic              far_server_i,
  input logic              rd_stb_i,
  input logic              clr_stb_i,
  input logic [WORD_W-1:0] clr_mask_i,
  input logic [WORD_W-1:0] held_w,
  input logic [WORD_W-1:0] rd_data_o
);
  localparam logic [63:0]       VALID_FULL = fe_valid_mask(PAY_POS, SRV_POS);
  localparam logic [WORD_W-1:0] VALID      = VALID_FULL[WORD_W-1:0];

  assert_payload_set_R2: assert property (@(posedge clk) disable iff (rst)
    far_payload_i |=> held_w[PAY_POS]);

  assert_server_set_R3: assert property (@(posedge clk) disable iff (rst)
    far_server_i |=> held_w[SRV_POS]);

  assert_payload_sticky_R1: assert property (@(posedge clk) disable iff (rst)
    (held_w[PAY_POS] && !(clr_stb_i && clr_mask_i[PAY_POS])) |=> held_w[PAY_POS]);

  assert_server_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_stb_i && clr_mask_i[SRV_POS] && !far_server_i) |=> !held_w[SRV_POS]);

  assert_clear_needs_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    (!clr_stb_i && held_w[PAY_POS]) |=> held_w[PAY_POS]);

  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_data_o & ~VALID) == '0);

  assert_read_capture_R7: assert property (@(posedge clk) disable iff (rst)
    rd_stb_i |=> rd_data_o == $past(held_w));

  assert_read_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_stb_i |=> $stable(rd_data_o));
endmodule

bind fe_status_latch fe_status_latch_chk #(
  .WORD_W(WORD_W), .PAY_POS(PAY_POS), .SRV_POS(SRV_POS)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .far_payload_i (far_payload_i),
  .far_server_i  (far_server_i),
  .rd_stb_i      (rd_stb_i),
  .clr_stb_i     (clr_stb_i),
  .clr_mask_i    (clr_mask_i),
  .held_w        (held_w),
  .rd_data_o     (rd_data_o)
);

// File: tb/fe_status_latch_bench.sv
module fe_status_latch_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pay = 1'b0;
  logic        srv = 1'b0;
  logic        rd  = 1'b0;
  logic        clr = 1'b0;
  logic [15:0] mask = '0;
  logic [15:0] rd_data;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int m_held = 0;
  int m_rd   = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  fe_status_latch u_fe_status_latch (
    .clk           (clk),
    .rst           (rst),
    .far_payload_i (pay),
    .far_server_i  (srv),
    .rd_stb_i      (rd),
    .rd_data_o     (rd_data),
    .clr_stb_i     (clr),
    .clr_mask_i    (mask)
  );

  // Reference model: bit 10 payload, bit 8 server, others zero.
  always @(posedge clk) begin
    cycles = cycles + 1;
    if (rst) begin
      m_held = 0;
      m_rd   = 0;
    end else begin
      if (rd) m_rd = m_held;
      if (clr) m_held = m_held & ~int'(mask);
      if (pay) m_held = m_held | 32'h400;
      if (srv) m_held = m_held | 32'h100;
      m_held = m_held & 32'h500;
    end
  end

  task automatic step(input bit r, input bit p, input bit s, input bit rdv,
                      input bit c, input logic [15:0] mk, input string tag);
    rst = r; pay = p; srv = s; rd = rdv; clr = c; mask = mk;
    @(negedge clk);
    checks = checks + 1;
    if (rd_data !== m_rd[15:0]) begin
      errors = errors + 1;
      $display("FAIL %s: rd_data=%h expected=%h", tag, rd_data, m_rd[15:0]);
    end
  endtask

  task automatic rd_expect(input logic [15:0] exp, input string tag);
    step(0, 0, 0, 1, 0, 16'h0, tag);
    checks = checks + 1;
    if (rd_data !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: rd_data=%h expected=%h", tag, rd_data, exp);
    end
  endtask

  initial begin
    @(negedge clk);
    step(1, 0, 0, 0, 0, 16'h0, "R8 reset");
    step(1, 1, 1, 1, 1, 16'hFFFF, "R8 reset");
    rd_expect(16'h0000, "R8 after reset");
    // R1/R2: one-cycle pulse latches into bit 10 and stays.
    step(0, 1, 0, 0, 0, 16'h0, "R2 pulse");
    step(0, 0, 0, 0, 0, 16'h0, "R1 idle");
    step(0, 0, 0, 0, 0, 16'h0, "R1 idle");
    rd_expect(16'h0400, "R2 payload bit10");
    // R3: server pulse into bit 8.
    step(0, 0, 1, 0, 0, 16'h0, "R3 pulse");
    rd_expect(16'h0500, "R3 server bit8");
    // R9: mask without strobe does nothing.
    step(0, 0, 0, 0, 0, 16'hFFFF, "R9 no strobe");
    rd_expect(16'h0500, "R9 mask ignored");
    // R7: read together with clear returns pre-clear word.
    step(0, 0, 0, 1, 1, 16'h0400, "R7 read+clear");
    checks = checks + 1;
    if (rd_data !== 16'h0500) begin
      errors = errors + 1;
      $display("FAIL R7 read+clear: rd_data=%h expected=%h", rd_data, 16'h0500);
    end
    // R5: only bit 10 went away.
    rd_expect(16'h0100, "R5 masked clear");
    // R7: output holds without strobe while state changes.
    step(0, 1, 0, 0, 0, 16'h0, "R7 hold");
    checks = checks + 1;
    if (rd_data !== 16'h0100) begin
      errors = errors + 1;
      $display("FAIL R7 hold: rd_data=%h expected=%h", rd_data, 16'h0100);
    end
    rd_expect(16'h0500, "R1 set seen");
    // R6: set coinciding with clear of same bit wins.
    step(0, 1, 0, 0, 1, 16'h0400, "R6 collide");
    rd_expect(16'h0500, "R6 set wins");
    // R6/R5: set of one bit while clearing the other.
    step(0, 0, 1, 0, 1, 16'h0400, "R6 other bit");
    rd_expect(16'h0100, "R6 server kept");
    // R1: level held through repeated clears stays set, then clears.
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 1, 16'h0500, "R1 level");
    rd_expect(16'h0400, "R1 level held");
    step(0, 0, 0, 0, 1, 16'h0400, "R5 clear");
    rd_expect(16'h0000, "R5 all clear");
    // R4: reserved bits never read 1 under any stimulus.
    step(0, 1, 1, 0, 1, 16'hFAFF, "R4 stimulus");
    rd_expect(16'h0500, "R4 reserved zero");
    step(0, 0, 0, 0, 1, 16'hFFFF, "R5 full clear");
    rd_expect(16'h0000, "R4 reserved after clear");
    // R8: reset mid-run.
    step(0, 1, 1, 0, 0, 16'h0, "R8 preset");
    step(1, 0, 0, 0, 0, 16'h0, "R8 midrun");
    rd_expect(16'h0000, "R8 midrun cleared");
    done = 1;
  end

  initial begin
    while (!done && cycles < 5000) @(posedge clk);
    if (!done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: done=%0d expected=1", done);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule